// File: doc/BRIEF.md
# Host Memory Window

This block lets a narrow, byte-wide host register bus reach a local memory that is 32 bits wide. The host first programs a word address and an access mode through two address registers. It then moves data through four data byte registers that together form one 32-bit word. On the other side, a request/acknowledge port reads or writes one word of local memory at a time.

There are two kinds of traffic. In auto-increment mode, a run of aligned words streams through the window. Reading byte 0 fetches a word and steps the pointer. Writing byte 3 commits the assembled word and steps the pointer. In the other modes, every data register access is a single-byte memory operation on a fixed address, so this is the path for unaligned or short transfers.

Any host access that needs memory is held off with a ready signal until the memory acknowledges.

Top module: `memwin_host`

## Requirements
- R1: After reset, both address registers read 0, the mode is 2'b00 and the held data word is 0.
- R2: Register index 0 is the low address register. Bits [7:2] hold word-address bits [5:0] (byte address bits [7:2]) and bits [1:0] hold the mode. Mode 2'b11 is auto-increment. Modes 2'b00, 2'b01 and 2'b10 are single-byte, non-incrementing access. The register reads back as written.
- R3: Register index 1 is the high address register. Bits [6:0] hold word-address bits [12:6], which are byte address bits [14:8]. A write to bit 7 is ignored and bit 7 reads 0.
- R4: Register indices 4 to 7 are data bytes B0 to B3, where B0 is the least significant byte of the word. Indices 2 and 3 read 0 and writes to them change nothing.
- R5: In auto-increment mode, a read of B0 issues one memory read of the current word. It returns byte 0 of that word, keeps the whole word as the held copy, and advances the word address by one.
- R6: In auto-increment mode, reads of B1 to B3 return bytes of the held copy. They issue no memory request and complete without wait.
- R7: In auto-increment mode, writes to B0 to B2 only update the held copy. A write to B3 issues one memory write of all four bytes (byte enable 4'b1111), with the written byte as byte 3, and then advances the word address by one.
- R8: The word address wraps from its top value (byte address 0x7FFC) to 0.
- R9: In the single-byte modes, each data access issues one memory operation on byte lane = register index minus 4. A write uses a one-hot byte enable on that lane. A read returns that lane of the fetched word. The word address does not change.
- R10: A host access that needs memory keeps `h_ready` low until the cycle that `m_ack` arrives. `m_req` and `m_addr` stay steady until that acknowledgement.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access request, held until `h_ready` |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_reg | input | 3 | Register index (0,1 address; 4..7 data B0..B3) |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid when `h_ready` |
| h_ready | output | 1 | Host access completes this cycle |
| m_req | output | 1 | Local memory request |
| m_we | output | 1 | Local memory write enable |
| m_addr | output | 13 | Local memory word address |
| m_be | output | 4 | Byte enables for writes |
| m_wdata | output | 32 | Local memory write word |
| m_rdata | input | 32 | Local memory read word, valid with `m_ack` |
| m_ack | input | 1 | Local memory completion |

## Verification
The assertions check the following on every cycle:
- the request stays steady until it is acknowledged;
- the address advances by exactly one word on each auto-increment completion, and stays fixed in single-byte mode;
- memory writes in auto-increment mode come only from B3;
- single-byte writes carry exactly one enable;
- mid-word reads never touch memory;
- the high address bit 7 reads 0.

Only the bench scenarios show the data path. This covers word contents fetched and flushed across runs, the held copy seen through B1 to B3, untouched neighbouring bytes in single-byte writes, wrap at the top of the space, and the address readback after each run.

// File: rtl/memwin_host.sv
module memwin_host #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_wr,
  input  logic [2:0]        h_reg,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic              h_ready,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-3:0] m_addr,
  output logic [3:0]        m_be,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  input  logic              m_ack
);
  localparam int WA_W = ADDR_W - 2;
  localparam int HI_W = ADDR_W - 8;

  logic [1:0]      mode;
  logic [WA_W-1:0] waddr;
  logic [31:0]     dreg;
  logic            pend;

  wire       is_data = h_reg[2];
  wire [1:0] lane    = h_reg[1:0];
  wire       auto_m  = (mode == 2'b11);
  wire       mem_op  = h_sel && is_data &&
                       (!auto_m || (h_wr ? (lane == 2'd3) : (lane == 2'd0)));
  wire       done    = pend && m_ack;
  wire       acc     = h_sel && h_ready;

  assign h_ready = !mem_op || done;
  assign m_req   = pend;
  assign m_addr  = waddr;
  assign m_we    = h_wr;
  assign m_be    = auto_m ? 4'hF : (4'b0001 << lane);
  assign m_wdata = auto_m ? {h_wdata, dreg[23:0]} : {4{h_wdata}};

  always_comb begin
    h_rdata = 8'h00;
    if (is_data)
      h_rdata = (done && !h_wr) ? m_rdata[lane*8 +: 8] : dreg[lane*8 +: 8];
    else if (lane == 2'd0)
      h_rdata = {waddr[5:0], mode};
    else if (lane == 2'd1)
      h_rdata = 8'(waddr[WA_W-1:6]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= 2'b00;
      waddr <= '0;
      dreg  <= '0;
      pend  <= 1'b0;
    end else begin
      if (mem_op && !pend) pend <= 1'b1;
      else if (done)       pend <= 1'b0;
      if (acc && !is_data && h_wr) begin
        if (lane == 2'd0) {waddr[5:0], mode} <= h_wdata;
        else if (lane == 2'd1) waddr[WA_W-1:6] <= h_wdata[HI_W-1:0];
      end
      if (acc && is_data) begin
        if (h_wr)      dreg[lane*8 +: 8] <= h_wdata;
        else if (done) dreg <= m_rdata;
        if (done && auto_m) waddr <= waddr + WA_W'(1);
      end
    end
  end

  // R10: request held steady until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr)));

  // R5 / R7 / R8: one word step per auto completion, wrapping
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && auto_m) |=> (m_addr == $past(m_addr) + WA_W'(1)));

  a_r9_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && !auto_m) |=> $stable(m_addr));

  a_r9_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && !auto_m) |-> ($countones(m_be) == 1));

  a_r7_flush_b3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we && auto_m) |-> (h_reg == 3'd7));

  a_r6_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && auto_m && is_data && lane != 2'd0) |-> (!m_req && h_ready));

  a_r3_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && h_reg == 3'd1) |-> (h_rdata[7] == 1'b0));
endmodule

// File: tb/memwin_host_tb.sv
`timescale 1ns/100ps
module memwin_host_tb;
  logic clk = 0, rst_n = 0;
  logic h_sel = 0, h_wr = 0;
  logic [2:0] h_reg = 0;
  logic [7:0] h_wdata = 0, h_rdata;
  logic h_ready, m_req, m_we, m_ack = 0;
  logic [12:0] m_addr;
  logic [3:0] m_be;
  logic [31:0] m_wdata, m_rdata = 0;

  always #2.5 clk = ~clk;

  memwin_host u_dut (.*);

  logic [31:0] mem [0:8191];
  int wait_cnt = 0, lat = 0, mem_ops = 0;
  int checks = 0, fails = 0, stall = 0;
  bit summary_done = 0;

  always @(negedge clk) begin
    if (m_ack) m_ack = 0;
    else if (m_req) begin
      if (wait_cnt >= lat) begin
        m_ack = 1;
        m_rdata = mem[m_addr];
        if (m_we)
          for (int b = 0; b < 4; b++)
            if (m_be[b]) mem[m_addr][b*8 +: 8] = m_wdata[b*8 +: 8];
        wait_cnt = 0;
        lat = (lat + 1) % 3;
        mem_ops++;
      end else wait_cnt++;
    end
  end

  function automatic [31:0] pat(input int i);
    pat = (32'(i) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hacc(input bit wr, input [2:0] r, input [7:0] wd, output [7:0] rd);
    int n;
    @(negedge clk);
    h_sel = 1; h_wr = wr; h_reg = r; h_wdata = wd;
    n = 0;
    forever begin
      #1;
      if (h_ready) break;
      @(negedge clk);
      n++;
      if (n > 50) begin
        checks++; fails++;
        $display("FAIL R10: actual no ready expected ready within 50 cycles");
        break;
      end
    end
    rd = h_rdata; stall = n;
    @(posedge clk); #1;
    h_sel = 0;
  endtask

  task automatic set_addr(input int w, input [1:0] md);
    logic [7:0] d;
    hacc(1, 3'd0, {w[5:0], md}, d);
    hacc(1, 3'd1, {1'b0, w[12:6]}, d);
  endtask

  task automatic chk_addr(input string req, input int w, input [1:0] md);
    logic [7:0] a, b;
    hacc(0, 3'd0, 0, a);
    hacc(0, 3'd1, 0, b);
    chk(req, {b, a}, {1'b0, w[12:6], w[5:0], md});
  endtask

  initial begin
    #1000000;
    if (!summary_done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int ops0;
    logic [31:0] exp;
    for (int i = 0; i < 8192; i++) mem[i] = pat(i);
    repeat (4) @(posedge clk);
    rst_n = 1;

    // R1 reset state
    hacc(0, 3'd0, 0, d); chk("R1 addr lo", d, 0);
    hacc(0, 3'd1, 0, d); chk("R1 addr hi", d, 0);
    hacc(1, 3'd0, 8'h03, d);
    ops0 = mem_ops;
    hacc(0, 3'd5, 0, d); chk("R1 data reg zero", d, 0);
    chk("R6 no fetch on B1", mem_ops, ops0);

    // R2/R3/R4 address registers and unmapped indices
    hacc(1, 3'd1, 8'hFF, d);
    hacc(0, 3'd1, 0, d); chk("R3 bit7 ignored", d, 8'h7F);
    hacc(1, 3'd0, 8'hA6, d);
    hacc(0, 3'd0, 0, d); chk("R2 lo readback", d, 8'hA6);
    hacc(1, 3'd2, 8'h55, d); hacc(1, 3'd3, 8'h77, d);
    hacc(0, 3'd2, 0, d); chk("R4 index2 reads 0", d, 0);
    hacc(0, 3'd3, 0, d); chk("R4 index3 reads 0", d, 0);
    chk_addr("R4 unmapped write ignored", 13'h1FE9, 2'b10);

    // R5/R6 auto read run
    set_addr(37, 2'b11);
    for (int k = 0; k < 16; k++) begin
      ops0 = mem_ops;
      hacc(0, 3'd4, 0, d); chk("R5 B0 fetch", d, pat(37 + k) & 32'hFF);
      if (k == 0) chk("R10 B0 stalls", stall >= 1, 1);
      for (int b = 1; b < 4; b++) begin
        hacc(0, 3'(4 + b), 0, d);
        chk("R6 held byte", d, (pat(37 + k) >> (8 * b)) & 32'hFF);
        if (b == 1) chk("R10 B1 no stall", stall, 0);
      end
      chk("R6 one memory op per word", mem_ops - ops0, 1);
    end
    chk_addr("R5 advanced", 37 + 16, 2'b11);

    // R7 auto write run
    set_addr(200, 2'b11);
    for (int k = 0; k < 8; k++) begin
      exp = pat(k + 5000);
      ops0 = mem_ops;
      for (int b = 0; b < 3; b++) hacc(1, 3'(4 + b), exp[b*8 +: 8], d);
      chk("R7 B0-B2 no memory op", mem_ops, ops0);
      chk("R7 memory unchanged before B3", mem[200 + k], pat(200 + k));
      hacc(1, 3'd7, exp[31:24], d);
      chk("R7 flushed word", mem[200 + k], exp);
    end
    chk_addr("R7 advanced", 208, 2'b11);

    // R8 wrap
    set_addr(13'h1FFF, 2'b11);
    hacc(0, 3'd4, 0, d); chk("R8 top word", d, pat(13'h1FFF) & 32'hFF);
    chk_addr("R8 wrap on read", 0, 2'b11);
    set_addr(13'h1FFF, 2'b11);
    for (int b = 0; b < 4; b++) hacc(1, 3'(4 + b), 8'(8'h10 * b + 1), d);
    chk("R8 top word written", mem[13'h1FFF], 32'h31211101);
    chk_addr("R8 wrap on write", 0, 2'b11);

    // R9 single-byte modes
    for (int md = 0; md < 3; md++) begin
      int w;
      w = 300 + 7 * md;
      set_addr(w, 2'(md));
      exp = mem[w];
      for (int b = 0; b < 4; b++) begin
        hacc(1, 3'(4 + b), 8'(8'hC0 + 16 * md + b), d);
        exp[b*8 +: 8] = 8'(8'hC0 + 16 * md + b);
        chk("R9 byte write lane only", mem[w], exp);
      end
      for (int b = 3; b >= 0; b--) begin
        mem[w][b*8 +: 8] = 8'(8'h3 * b + md);
        hacc(0, 3'(4 + b), 0, d);
        chk("R9 byte read lane", d, 8'(8'h3 * b + md));
      end
      chk_addr("R9 address fixed", w, 2'(md));
    end

    summary_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule